// File: doc/BRIEF.md
# SDIO Read-Wait Clock Gating Controller

This block owns the card clock of an SDIO host during a multi-block read. It divides the host clock down to a free-running card clock. It also watches a strobe that marks the end bit of each received block. When software has picked the clock-freeze form of read-wait and has raised a read-wait request, the block holds the card in read-wait by stopping the clock. The clock stops a fixed number of card-clock cycles after the end bit of the block in flight, and it always stops in the low phase. The clock comes back only once software sets the start control.

While the clock is frozen, the block raises a flag that tells the command path it may send any command to the card. Whether the clock runs or not, the block samples data line 1 on the host clock to catch card interrupts. It keeps a sticky status bit that software clears by writing 1, and it drives a maskable interrupt request. Block data capture, CRC checking and FIFO handling sit elsewhere.

Top module: `sdio_rw_clkgate`

## Requirements
- R1: While reset is asserted, `cardClk`, `cmdAllowed`, `intStatus` and `intReq` are all 0, and the clock gate is open.
- R2: While no stop is in force, `cardClk` runs freely. It is high for HALF_DIV host cycles and then low for HALF_DIV host cycles.
- R3: When `modeClkStop` and `rwRequest` are both 1, the clock stops after `blockEnd` has been sampled. The stop falls on the STOP_EDGES-th (default 2) falling edge of `cardClk` after that sample. The clock then stays low for as long as it is stopped.
- R4: With `modeClkStop` at 0, an end strobe never stops the clock, even when `rwRequest` is 1.
- R5: A request raised before any end strobe leaves the clock running. The stop waits for the next end strobe plus the STOP_EDGES falling edges.
- R6: A stopped clock resumes only at a card-clock phase boundary at which `rwStart` is 1. Its first sample after it resumes is low, and its first high phase lasts the full HALF_DIV host cycles.
- R7: `cmdAllowed` is 1 exactly while the card clock is stopped.
- R8: With `sdioEn` at 1, a sample of `dataD1` that is 0 after a sample of 1 sets `intStatus` on the next clock edge. This holds while the clock is stopped as well. With `sdioEn` at 0, falls on `dataD1` are ignored.
- R9: `intStatus` is sticky and is cleared by `intClear`. If a new detection and `intClear` come in the same cycle, the detection wins.
- R10: `intReq` is 1 only when `intStatus` and `intMask` are both 1.
- R11: `cardClk` never produces a high pulse shorter than HALF_DIV host cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blockEnd | input | 1 | One-cycle strobe marking the end bit of a received block |
| modeClkStop | input | 1 | Selects clock-freeze read-wait |
| rwRequest | input | 1 | Read-wait requested |
| rwStart | input | 1 | Read-wait start control; releases a stopped clock |
| sdioEn | input | 1 | Enables card interrupt detection on data line 1 |
| dataD1 | input | 1 | Data line 1, card interrupt is active low |
| intClear | input | 1 | Write-1 clear of the interrupt status |
| intMask | input | 1 | Interrupt request enable |
| cardClk | output | 1 | Gated card clock |
| cmdAllowed | output | 1 | Command issue permitted while the clock is frozen |
| intStatus | output | 1 | Sticky card interrupt status |
| intReq | output | 1 | Masked interrupt request |

## Verification
A behavioural model in the bench steps alongside the design and is compared with it on every clock. The stop path is tried three ways: with the request raised long before the end strobe, with the clock-freeze mode turned off, and with a release followed by a second stop. Between them these separate "stop after the end strobe" from "stop as soon as asked" and from "stop in any mode". Counting clock falls between the strobe and the freeze catches an off-by-one in the delay. Measuring the first high phase after a release catches a gate that opens mid-phase. Interrupt patterns drop data line 1 while the clock is frozen, drop it with detection disabled, and line up a fresh detection with a clear in the same cycle. These show that sampling runs on regardless of the gate, that the enable is honoured, and that a new detection takes priority over the clear.

// File: rtl/sdio_rw_pkg.sv
`timescale 1ns/1ps
package sdio_rw_pkg;

  typedef enum logic [1:0] {
    RW_RUN   = 2'd0,
    RW_COUNT = 2'd1,
    RW_HALT  = 2'd2
  } rwState_t;

  typedef struct packed {
    logic armCnt;
    logic incCnt;
    logic stopGate;
    logic startGate;
  } rwStrobe_t;

endpackage

// File: rtl/sdio_rw_datapath.sv
`timescale 1ns/1ps
module sdio_rw_datapath
  import sdio_rw_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int STOP_EDGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rwStrobe_t strobe,
  input  logic      dataD1,
  input  logic      sdioEn,
  input  logic      intClear,
  input  logic      intMask,
  output logic      fallEvt,
  output logic      lastEdge,
  output logic      cardClk,
  output logic      intStatus,
  output logic      intReq
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = (STOP_EDGES > 1) ? $clog2(STOP_EDGES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(STOP_EDGES - 1);

  logic [DIV_W-1:0] divCnt;
  logic             phase;
  logic             divWrap;
  logic [CNT_W-1:0] edgeCnt;
  logic             gateOpen;
  logic             d1Prev;
  logic             d1Detect;

  // free-running divider; phase toggles every HALF_DIV host cycles
  assign divWrap = (divCnt == DIV_LAST);
  assign fallEvt = divWrap & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (divWrap) begin
      divCnt <= '0;
      phase  <= ~phase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // falling-edge counter after a block end bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCnt <= '0;
    end else if (strobe.armCnt) begin
      edgeCnt <= '0;
    end else if (strobe.incCnt) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign lastEdge = (edgeCnt == EDGE_LAST);

  // gate only moves on a phase boundary where the clock goes low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateOpen <= 1'b1;
    end else if (strobe.stopGate) begin
      gateOpen <= 1'b0;
    end else if (strobe.startGate) begin
      gateOpen <= 1'b1;
    end
  end

  assign cardClk = phase & gateOpen;

  // card interrupt: active-low level on line 1, edge recorded on the fall
  assign d1Detect = sdioEn & d1Prev & ~dataD1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1Prev    <= 1'b1;
      intStatus <= 1'b0;
    end else begin
      d1Prev    <= dataD1;
      intStatus <= d1Detect | (intStatus & ~intClear);
    end
  end

  assign intReq = intStatus & intMask;

endmodule

// File: rtl/sdio_rw_control.sv
`timescale 1ns/1ps
module sdio_rw_control
  import sdio_rw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      blockEnd,
  input  logic      modeClkStop,
  input  logic      rwRequest,
  input  logic      rwStart,
  input  logic      fallEvt,
  input  logic      lastEdge,
  output rwStrobe_t strobe,
  output logic      cmdAllowed
);

  rwState_t state;
  rwState_t stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      RW_RUN: begin
        if (blockEnd) begin
          strobe.armCnt = 1'b1;
          stateNext     = RW_COUNT;
        end
      end
      RW_COUNT: begin
        if (blockEnd) begin
          strobe.armCnt = 1'b1;
        end else if (fallEvt) begin
          if (lastEdge) begin
            if (modeClkStop && rwRequest) begin
              strobe.stopGate = 1'b1;
              stateNext       = RW_HALT;
            end else begin
              stateNext = RW_RUN;
            end
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
      end
      RW_HALT: begin
        if (fallEvt && rwStart) begin
          strobe.startGate = 1'b1;
          stateNext        = RW_RUN;
        end
      end
      default: stateNext = RW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RW_RUN;
    else        state <= stateNext;
  end

  assign cmdAllowed = (state == RW_HALT);

endmodule

// File: rtl/sdio_rw_clkgate.sv
`timescale 1ns/1ps
module sdio_rw_clkgate
  import sdio_rw_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int STOP_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blockEnd,
  input  logic modeClkStop,
  input  logic rwRequest,
  input  logic rwStart,
  input  logic sdioEn,
  input  logic dataD1,
  input  logic intClear,
  input  logic intMask,
  output logic cardClk,
  output logic cmdAllowed,
  output logic intStatus,
  output logic intReq
);

  rwStrobe_t strobe;
  logic      fallEvt;
  logic      lastEdge;

  sdio_rw_control u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .blockEnd    (blockEnd),
    .modeClkStop (modeClkStop),
    .rwRequest   (rwRequest),
    .rwStart     (rwStart),
    .fallEvt     (fallEvt),
    .lastEdge    (lastEdge),
    .strobe      (strobe),
    .cmdAllowed  (cmdAllowed)
  );

  sdio_rw_datapath #(
    .HALF_DIV   (HALF_DIV),
    .STOP_EDGES (STOP_EDGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .dataD1    (dataD1),
    .sdioEn    (sdioEn),
    .intClear  (intClear),
    .intMask   (intMask),
    .fallEvt   (fallEvt),
    .lastEdge  (lastEdge),
    .cardClk   (cardClk),
    .intStatus (intStatus),
    .intReq    (intReq)
  );

endmodule

// File: rtl/sdio_rw_clkgate_chk.sv
`timescale 1ns/1ps
module sdio_rw_clkgate_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic modeClkStop,
  input logic rwRequest,
  input logic rwStart,
  input logic sdioEn,
  input logic intClear,
  input logic intMask,
  input logic cardClk,
  input logic cmdAllowed,
  input logic intStatus,
  input logic intReq
);

  logic [15:0] highLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       highLen <= '0;
    else if (cardClk) highLen <= highLen + 1'b1;
    else              highLen <= '0;
  end

  // R11
  no_runt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cardClk) |-> (highLen == 16'(HALF_DIV)));

  // R7
  cmd_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdAllowed |-> !cardClk);

  // R6
  restart_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmdAllowed) |-> $past(rwStart));

  // R4
  stop_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdAllowed) |-> $past(modeClkStop && rwRequest));

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intStatus && !intClear) |=> intStatus);

  // R8
  detect_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdioEn && !intStatus) |=> !intStatus);

  // R10
  req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intReq |-> (intMask && intStatus));

endmodule

bind sdio_rw_clkgate sdio_rw_clkgate_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .modeClkStop (modeClkStop),
  .rwRequest   (rwRequest),
  .rwStart     (rwStart),
  .sdioEn      (sdioEn),
  .intClear    (intClear),
  .intMask     (intMask),
  .cardClk     (cardClk),
  .cmdAllowed  (cmdAllowed),
  .intStatus   (intStatus),
  .intReq      (intReq)
);

// File: tb/sdio_rw_clkgate_tb_top.sv
`timescale 1ns/1ps
module sdio_rw_clkgate_tb_top;

  localparam int HALF_DIV   = 2;
  localparam int STOP_EDGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blockEnd = 1'b0, modeClkStop = 1'b0, rwRequest = 1'b0, rwStart = 1'b0;
  logic sdioEn = 1'b0, dataD1 = 1'b1, intClear = 1'b0, intMask = 1'b0;
  logic cardClk, cmdAllowed, intStatus, intReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdio_rw_clkgate #(.HALF_DIV(HALF_DIV), .STOP_EDGES(STOP_EDGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .blockEnd(blockEnd), .modeClkStop(modeClkStop),
    .rwRequest(rwRequest), .rwStart(rwStart), .sdioEn(sdioEn), .dataD1(dataD1),
    .intClear(intClear), .intMask(intMask), .cardClk(cardClk),
    .cmdAllowed(cmdAllowed), .intStatus(intStatus), .intReq(intReq)
  );

  // behavioural reference: integer counters, stopped/armed flags
  int  mTick, mFalls;
  bit  mHigh, mRunning, mArmed, mStopped, mLineWas, mFlag;

  always @(posedge clk) begin
    if (!rst_n) begin
      mTick = 0; mHigh = 0; mRunning = 1; mArmed = 0; mStopped = 0;
      mFalls = 0; mLineWas = 1; mFlag = 0;
    end else begin
      bit boundaryFall;
      boundaryFall = (mTick == HALF_DIV - 1) && mHigh;
      if (!mStopped && blockEnd) begin
        mArmed = 1; mFalls = 0;
      end else if (mArmed && boundaryFall) begin
        mFalls++;
        if (mFalls == STOP_EDGES) begin
          mArmed = 0;
          if (modeClkStop && rwRequest) begin mStopped = 1; mRunning = 0; end
        end
      end else if (mStopped && boundaryFall && rwStart) begin
        mStopped = 0; mRunning = 1;
      end
      mTick++;
      if (mTick == HALF_DIV) begin mTick = 0; mHigh = !mHigh; end
      mFlag = (sdioEn && mLineWas && !dataD1) || (mFlag && !intClear);
      mLineWas = dataD1;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 R6 cardClk", cardClk, mHigh && mRunning);
      chk("R7 cmdAllowed", cmdAllowed, mStopped);
      chk("R8 R9 intStatus", intStatus, mFlag);
      chk("R10 intReq", intReq, mFlag && intMask);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulseEnd();
    blockEnd = 1'b1; cyc(1); blockEnd = 1'b0;
  endtask

  // counts cardClk falls until the clock is reported frozen
  task automatic fallsToStop(output int falls);
    bit prev;
    falls = 0;
    prev = cardClk;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (prev && !cardClk) falls++;
      prev = cardClk;
      if (cmdAllowed) break;
    end
  endtask

  task automatic highLenNext(output int len);
    len = 0;
    for (int i = 0; i < 200 && !cardClk; i++) @(negedge clk);
    for (int i = 0; i < 200 && cardClk; i++) begin len++; @(negedge clk); end
  endtask

  initial begin
    int n;
    bit sawStop;
    cyc(3);
    // R1
    chk("R1 cardClk", cardClk, 1'b0);
    chk("R1 cmdAllowed", cmdAllowed, 1'b0);
    chk("R1 intStatus", intStatus, 1'b0);
    chk("R1 intReq", intReq, 1'b0);
    rst_n = 1'b1;
    cyc(20);
    // R2
    highLenNext(n);
    chk("R2 high length", n == HALF_DIV, 1'b1);

    // R5: request long before end strobe
    modeClkStop = 1'b1; rwRequest = 1'b1;
    sawStop = 1'b0;
    for (int i = 0; i < 30; i++) begin cyc(1); if (cmdAllowed) sawStop = 1'b1; end
    chk("R5 no early stop", sawStop, 1'b0);
    pulseEnd();
    fallsToStop(n);
    chk("R3 falls to stop", n == STOP_EDGES, 1'b1);
    chk("R3 R7 frozen", cmdAllowed, 1'b1);

    // R8: interrupt while frozen
    sdioEn = 1'b1; intMask = 1'b1;
    cyc(3); dataD1 = 1'b0; cyc(2);
    chk("R8 detect while frozen", intStatus, 1'b1);
    chk("R10 request", intReq, 1'b1);
    chk("R3 clock held low", cardClk, 1'b0);
    intMask = 1'b0; cyc(1);
    chk("R10 masked", intReq, 1'b0);
    dataD1 = 1'b1; intClear = 1'b1; cyc(1); intClear = 1'b0; cyc(1);
    chk("R9 cleared", intStatus, 1'b0);
    cyc(15);
    chk("R6 still frozen without start", cmdAllowed, 1'b1);

    // R6: release
    rwRequest = 1'b0; rwStart = 1'b1;
    for (int i = 0; i < 50 && cmdAllowed; i++) @(negedge clk);
    chk("R6 resumes low", cardClk, 1'b0);
    #1 rwStart = 1'b0;
    highLenNext(n);
    chk("R6 first high full", n == HALF_DIV, 1'b1);

    // second stop then release
    rwRequest = 1'b1; cyc(5); pulseEnd();
    fallsToStop(n);
    chk("R3 second stop", n == STOP_EDGES, 1'b1);
    rwRequest = 1'b0; rwStart = 1'b1; cyc(12); rwStart = 1'b0;
    chk("R6 released again", cmdAllowed, 1'b0);

    // R4: mode off
    modeClkStop = 1'b0; rwRequest = 1'b1; cyc(3); pulseEnd();
    sawStop = 1'b0;
    for (int i = 0; i < 30; i++) begin cyc(1); if (cmdAllowed) sawStop = 1'b1; end
    chk("R4 no stop when mode off", sawStop, 1'b0);
    rwRequest = 1'b0;

    // R8: detection disabled
    sdioEn = 1'b0; dataD1 = 1'b0; cyc(3);
    chk("R8 ignored when disabled", intStatus, 1'b0);
    dataD1 = 1'b1; cyc(2);

    // R9: detection and clear together
    sdioEn = 1'b1; dataD1 = 1'b0; cyc(1); dataD1 = 1'b1; cyc(2);
    chk("R9 set", intStatus, 1'b1);
    dataD1 = 1'b0; intClear = 1'b1; cyc(1); intClear = 1'b0;
    chk("R9 detection beats clear", intStatus, 1'b1);
    cyc(2);
    chk("R9 sticky", intStatus, 1'b1);
    dataD1 = 1'b1; intClear = 1'b1; cyc(1); intClear = 1'b0; cyc(1);
    chk("R9 clear alone", intStatus, 1'b0);
    cyc(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule